// File: doc/BRIEF.md
# Elitist Recombination Genetic-Operator Unit

This block carries out one generation step of a genetic algorithm whose individuals are 4-bit chromosomes, each stored with an 8-bit fitness score in an external chromosome memory. A step starts with a one-cycle pulse on `step_go`. The unit reads a pair of parents from two adjacent memory words. It then breeds two children from them, using single-point crossover followed by per-bit mutation. The children go out one at a time over a request/acknowledge handshake to an external evaluator, which returns their fitness. Finally, the fittest two of the four individuals are written back over the parents' words.

Replacement is local. Only the pair that was read can change, and no ordering of the wider population is ever built. The pair chosen for each step comes from a fixed odd stride added to a pair counter, so successive steps visit every pair once before any pair repeats. A 32-bit pseudo-random generator supplies the crossover point and the mutation decisions. Deciding when to run steps and computing fitness both stay outside the block.

Top module: `ga_elite_unit`

## Requirements
- R1: Out of reset, `mem_re`, `mem_we`, `eval_req` and `step_done` are all low, the pair counter is 0 and the generator holds the SEED parameter.
- R2: A step on pair p reads word 2p in the first cycle after `step_go` is accepted and word 2p+1 in the next cycle. Read data arrives one cycle after each strobe. The first pair is 0, and each step moves p to (p + STRIDE) modulo 2^(ADDR_W-1). No other words are touched.
- R3: The generator is a right-shifting Galois register: if bit 0 is 1, the next state is (s>>1) XOR 0x80200003, otherwise it is s>>1. It advances exactly three times per step. The first value gives the cut, the second gives the mutation bits of child A and the third gives those of child B.
- R4: The cut c equals (bits 7:0 of the first value) mod 3, plus 1. Child A takes parent A's bits above c and parent B's low c bits. Child B takes parent B's bits above c and parent A's low c bits.
- R5: Bit i of a crossed child is inverted when byte i of that child's generator value (bits 8i+7:8i) is below `mut_thresh`. A threshold of 0 never mutates.
- R6: Child A is offered first, then child B. `eval_req` stays high and `eval_chrom` stays stable until `eval_ack`. The fitness on `eval_fit` is taken in the cycle `eval_ack` is high.
- R7: The four candidates are ranked in the order parent A, parent B, child A, child B. The highest fitness wins, and a tie goes to the earlier candidate. The winner is written to word 2p, then the runner-up (chosen the same way from the other three) to word 2p+1, in consecutive cycles. Each word is packed as {fitness[7:0], chromosome[3:0]}.
- R8: `step_done` is high for exactly one cycle, in the cycle right after the second write. `step_go` is ignored while a step is running.
- R9: A read and a write are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_go | input | 1 | Starts one step when the unit is idle |
| mut_thresh | input | 8 | Mutation threshold compared with each random byte |
| mem_re | output | 1 | Chromosome memory read strobe |
| mem_we | output | 1 | Chromosome memory write strobe |
| mem_addr | output | ADDR_W | Word address for the read or write |
| mem_wdata | output | 12 | Write word {fitness, chromosome} |
| mem_rdata | input | 12 | Read word, valid one cycle after `mem_re` |
| eval_req | output | 1 | A child is offered for evaluation |
| eval_chrom | output | 4 | Chromosome of the child being offered |
| eval_ack | input | 1 | Evaluator accepts the child and returns its fitness |
| eval_fit | input | 8 | Fitness of the offered child |
| step_done | output | 1 | One-cycle pulse when a step has finished |

## Verification
Once `step_go` has been sampled, the step follows a fixed schedule. Read strobes appear 1 and 2 cycles later. The first child is offered 6 cycles after the go edge. The second child is offered in the cycle after the first acknowledge. The two writes follow in the 1st and 2nd cycles after the second acknowledge, and `step_done` comes in the 3rd. The bench drives inputs and samples outputs on the falling edge, and it walks through that schedule one falling edge at a time. It checks each strobe, address and offered chromosome at the exact edge where it is due. It compares the whole memory with its own model only after `step_done`. Evaluator delays of 0 to 2 cycles stretch the two handshake waits, and the bench re-aligns on `eval_req` rather than on a fixed count.

// File: rtl/ga_pkg.sv
package ga_pkg;
  localparam int CHROM_W = 4;
  localparam int FIT_W   = 8;
  localparam int RNG_W   = 8 * CHROM_W;
  localparam logic [RNG_W-1:0] RNG_TAPS = 32'h8020_0003;

  typedef logic [CHROM_W-1:0] chrom_t;
  typedef logic [FIT_W-1:0]   fit_t;

  typedef struct packed {
    fit_t   fit;
    chrom_t chrom;
  } indiv_t;

  localparam int IND_W = $bits(indiv_t);

  typedef enum logic [3:0] {
    S_IDLE, S_RDA, S_RDB, S_CAPB, S_MUTA, S_MUTB,
    S_EVA, S_EVB, S_WRA, S_WRB, S_FIN
  } ga_state_e;

  // one generator step (right-shifting Galois form)
  function automatic logic [RNG_W-1:0] rng_next(logic [RNG_W-1:0] s);
    return s[0] ? ((s >> 1) ^ RNG_TAPS) : (s >> 1);
  endfunction

  // crossover point in 1..CHROM_W-1
  function automatic logic [1:0] cut_pick(logic [7:0] r);
    logic [7:0] m;
    m = r % 8'(CHROM_W - 1);
    return m[1:0] + 2'd1;
  endfunction

  // bits above the cut from hi_src, low 'cut' bits from lo_src
  function automatic chrom_t splice(chrom_t hi_src, chrom_t lo_src, logic [1:0] cut);
    chrom_t low_m;
    low_m = (chrom_t'(1) << cut) - chrom_t'(1);
    return (hi_src & ~low_m) | (lo_src & low_m);
  endfunction

  // per-bit mutation: byte i of r decides bit i
  function automatic chrom_t flip_bits(chrom_t c, logic [RNG_W-1:0] r, logic [7:0] thr);
    chrom_t o;
    o = c;
    for (int i = 0; i < CHROM_W; i++)
      if (r[8*i +: 8] < thr) o[i] = ~c[i];
    return o;
  endfunction
endpackage

// File: rtl/ga_rng.sv
module ga_rng
  import ga_pkg::*;
#(
  parameter logic [RNG_W-1:0] SEED = 32'h5EED_C0DE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [RNG_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n)   value <= SEED;
    else if (adv) value <= rng_next(value);
  end
endmodule

// File: rtl/ga_breed.sv
module ga_breed
  import ga_pkg::*;
(
  input  chrom_t           par_a,
  input  chrom_t           par_b,
  input  logic [1:0]       cut,
  input  logic [RNG_W-1:0] rnd,
  input  logic [7:0]       thr,
  input  logic             second,
  output chrom_t           child
);
  chrom_t crossed;

  always_comb begin
    crossed = second ? splice(par_b, par_a, cut) : splice(par_a, par_b, cut);
    child   = flip_bits(crossed, rnd, thr);
  end
endmodule

// File: rtl/ga_elite_sel.sv
module ga_elite_sel
  import ga_pkg::*;
(
  input  indiv_t [3:0] cand,
  output indiv_t       best,
  output indiv_t       runner
);
  logic [1:0] bi;
  logic [1:0] si;

  always_comb begin
    bi = 2'd0;
    for (int j = 1; j < 4; j++)
      if (cand[j].fit > cand[bi].fit) bi = 2'(j);
    si = (bi == 2'd0) ? 2'd1 : 2'd0;
    for (int j = 0; j < 4; j++)
      if (2'(j) != bi && 2'(j) != si && cand[j].fit > cand[si].fit) si = 2'(j);
    best   = cand[bi];
    runner = cand[si];
  end
endmodule

// File: rtl/ga_elite_unit.sv
module ga_elite_unit
  import ga_pkg::*;
#(
  parameter int                ADDR_W = 11,
  parameter int                STRIDE = 683,
  parameter logic [RNG_W-1:0]  SEED   = 32'h5EED_C0DE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_go,
  input  logic [7:0]        mut_thresh,
  output logic              mem_re,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [IND_W-1:0]  mem_wdata,
  input  logic [IND_W-1:0]  mem_rdata,
  output logic              eval_req,
  output logic [CHROM_W-1:0] eval_chrom,
  input  logic              eval_ack,
  input  logic [FIT_W-1:0]  eval_fit,
  output logic              step_done
);
  localparam int PAIR_W = ADDR_W - 1;

  ga_state_e          state;
  logic [PAIR_W-1:0]  pair_q;
  indiv_t             par_a, par_b;
  logic [1:0]         cut_q;
  chrom_t             kid_a, kid_b;
  fit_t               fit_a, fit_b;

  // named internal events
  logic               draw;
  logic               eval_fire;
  logic               odd_word;
  logic [RNG_W-1:0]   rnd;
  chrom_t             bred;
  indiv_t             best, runner;
  indiv_t [3:0]       cand;

  assign draw      = (state == S_CAPB) || (state == S_MUTA) || (state == S_MUTB);
  assign eval_fire = eval_req && eval_ack;
  assign odd_word  = (state == S_RDB) || (state == S_WRB);

  ga_rng #(.SEED(SEED)) u_rng (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (draw),
    .value (rnd)
  );

  ga_breed u_breed (
    .par_a  (par_a.chrom),
    .par_b  (par_b.chrom),
    .cut    (cut_q),
    .rnd    (rnd),
    .thr    (mut_thresh),
    .second (state == S_MUTB),
    .child  (bred)
  );

  assign cand[0] = par_a;
  assign cand[1] = par_b;
  assign cand[2] = '{fit: fit_a, chrom: kid_a};
  assign cand[3] = '{fit: fit_b, chrom: kid_b};

  ga_elite_sel u_sel (
    .cand   (cand),
    .best   (best),
    .runner (runner)
  );

  assign mem_re     = (state == S_RDA) || (state == S_RDB);
  assign mem_we     = (state == S_WRA) || (state == S_WRB);
  assign mem_addr   = {pair_q, odd_word};
  assign mem_wdata  = (state == S_WRB) ? runner : best;
  assign eval_req   = (state == S_EVA) || (state == S_EVB);
  assign eval_chrom = (state == S_EVB) ? kid_b : kid_a;
  assign step_done  = (state == S_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      pair_q <= '0;
      par_a  <= '0;
      par_b  <= '0;
      cut_q  <= 2'd1;
      kid_a  <= '0;
      kid_b  <= '0;
      fit_a  <= '0;
      fit_b  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (step_go) state <= S_RDA;
        S_RDA:  state <= S_RDB;
        S_RDB: begin
          par_a <= indiv_t'(mem_rdata);
          state <= S_CAPB;
        end
        S_CAPB: begin
          par_b <= indiv_t'(mem_rdata);
          cut_q <= cut_pick(rnd[7:0]);
          state <= S_MUTA;
        end
        S_MUTA: begin
          kid_a <= bred;
          state <= S_MUTB;
        end
        S_MUTB: begin
          kid_b <= bred;
          state <= S_EVA;
        end
        S_EVA: if (eval_fire) begin
          fit_a <= eval_fit;
          state <= S_EVB;
        end
        S_EVB: if (eval_fire) begin
          fit_b <= eval_fit;
          state <= S_WRA;
        end
        S_WRA: state <= S_WRB;
        S_WRB: state <= S_FIN;
        S_FIN: begin
          pair_q <= pair_q + PAIR_W'(STRIDE);
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ga_elite_unit_chk.sv
module ga_elite_unit_chk
  import ga_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_re,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [FIT_W-1:0]  wr_fit,
  input logic              eval_req,
  input logic              eval_ack,
  input logic [CHROM_W-1:0] eval_chrom,
  input logic              step_done,
  input logic              draw
);
  logic [2:0] draws;

  always_ff @(posedge clk) begin
    if (!rst_n)         draws <= '0;
    else if (step_done) draws <= '0;
    else if (draw)      draws <= draws + 3'd1;
  end

  // R9
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_re, mem_we}));

  // R6
  eval_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_req && !eval_ack |=> eval_req && $stable(eval_chrom));

  // R2
  rd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re && !mem_addr[0] |=> mem_re && mem_addr == $past(mem_addr) + 1'b1);

  // R7
  wr_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && !mem_addr[0] |=> mem_we && mem_addr == $past(mem_addr) + 1'b1
                                && wr_fit <= $past(wr_fit));

  // R8
  done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> $past(mem_we) && $past(mem_addr[0]) && !mem_we);

  // R3
  draw_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> draws == 3'd3);
endmodule

bind ga_elite_unit ga_elite_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_re     (mem_re),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .wr_fit     (mem_wdata[ga_pkg::IND_W-1 -: ga_pkg::FIT_W]),
  .eval_req   (eval_req),
  .eval_ack   (eval_ack),
  .eval_chrom (eval_chrom),
  .step_done  (step_done),
  .draw       (draw)
);

// File: tb/ga_elite_unit_bench.sv
`timescale 1ns/1ps
module ga_elite_unit_bench;
  localparam int AW     = 4;
  localparam int NW     = 1 << AW;
  localparam int NP     = NW / 2;
  localparam int STRIDE = 3;
  localparam logic [31:0] SEED = 32'hC0DE_1234;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        step_go = 0;
  logic [7:0]  mut_thresh = 0;
  logic        mem_re, mem_we;
  logic [AW-1:0] mem_addr;
  logic [11:0] mem_wdata;
  logic [11:0] mem_rdata;
  logic        eval_req;
  logic [3:0]  eval_chrom;
  logic        eval_ack = 0;
  logic [7:0]  eval_fit = 0;
  logic        step_done;

  logic        load = 0;
  int          mode = 0;
  logic [11:0] mem [NW];
  logic [11:0] exp_mem [NW];
  int          n_cmp = 0;
  int          n_bad = 0;
  logic [31:0] rng_m = SEED;
  int          pair_m = 0;

  always #2.5 clk = ~clk;

  ga_elite_unit #(.ADDR_W(AW), .STRIDE(STRIDE), .SEED(SEED)) u_ga_elite_unit (
    .clk(clk), .rst_n(rst_n), .step_go(step_go), .mut_thresh(mut_thresh),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .eval_req(eval_req), .eval_chrom(eval_chrom), .eval_ack(eval_ack),
    .eval_fit(eval_fit), .step_done(step_done)
  );

  function automatic logic [7:0] fit_of(logic [3:0] c, int md);
    int ones;
    ones = 0;
    for (int i = 0; i < 4; i++) ones += int'(c[i]);
    if (md == 0) return 8'((int'(c) * 37 + 11) % 256);
    return 8'(ones * 10);
  endfunction

  function automatic logic [11:0] init_word(int i, int md);
    logic [3:0] c;
    c = 4'((i * 7 + md * 5 + 3) % 16);
    return {fit_of(c, md), c};
  endfunction

  always @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < NW; i++) mem[i] <= init_word(i, mode);
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
    end
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] step_rng(logic [31:0] s);
    logic [31:0] t;
    t = {1'b0, s[31:1]};
    if (s[0]) t = t ^ 32'h8020_0003;
    return t;
  endfunction

  function automatic logic [3:0] make_child(logic [3:0] hi, logic [3:0] lo, int cut,
                                            logic [31:0] r, logic [7:0] thr);
    logic [3:0] k;
    for (int i = 0; i < 4; i++) begin
      k[i] = (i < cut) ? lo[i] : hi[i];
      if (int'(r[8*i +: 8]) < int'(thr)) k[i] = ~k[i];
    end
    return k;
  endfunction

  task automatic reload(input int md);
    @(negedge clk);
    mode = md;
    load = 1;
    for (int i = 0; i < NW; i++) exp_mem[i] = init_word(i, md);
    @(negedge clk);
    load = 0;
  endtask

  task automatic run_step(input logic [7:0] thr, input int dly, input bit poke_go);
    logic [11:0] pa, pb;
    logic [11:0] cand [4];
    int cut, bi, si, bad_other;
    logic [3:0] ca, cb;
    pa  = exp_mem[2*pair_m];
    pb  = exp_mem[2*pair_m + 1];
    cut = (int'(rng_m[7:0]) % 3) + 1;
    rng_m = step_rng(rng_m);
    ca  = make_child(pa[3:0], pb[3:0], cut, rng_m, thr);
    rng_m = step_rng(rng_m);
    cb  = make_child(pb[3:0], pa[3:0], cut, rng_m, thr);
    rng_m = step_rng(rng_m);
    cand[0] = pa; cand[1] = pb;
    cand[2] = {fit_of(ca, mode), ca};
    cand[3] = {fit_of(cb, mode), cb};
    bi = 0;
    for (int j = 1; j < 4; j++) if (cand[j][11:4] > cand[bi][11:4]) bi = j;
    si = -1;
    for (int j = 0; j < 4; j++)
      if (j != bi && (si < 0 || cand[j][11:4] > cand[si][11:4])) si = j;

    @(negedge clk);
    mut_thresh = thr;
    step_go = 1;
    @(negedge clk);
    step_go = 0;
    chk("R2 first read", {31'd0, mem_re} << 8 | 32'(mem_addr), (32'd1 << 8) | 32'(2*pair_m));
    @(negedge clk);
    chk("R2 second read", {31'd0, mem_re} << 8 | 32'(mem_addr), (32'd1 << 8) | 32'(2*pair_m + 1));
    while (!eval_req) @(negedge clk);
    chk("R4 R5 child A", 32'(eval_chrom), 32'(ca));
    if (poke_go) begin
      step_go = 1;
      @(negedge clk);
      step_go = 0;
    end
    repeat (dly) @(negedge clk);
    chk("R6 child A held", 32'(eval_chrom), 32'(ca));
    eval_ack = 1;
    eval_fit = fit_of(ca, mode);
    @(negedge clk);
    eval_ack = 0;
    chk("R6 R5 child B", {31'd0, eval_req} << 4 | 32'(eval_chrom), (32'd1 << 4) | 32'(cb));
    repeat (dly) @(negedge clk);
    eval_ack = 1;
    eval_fit = fit_of(cb, mode);
    @(negedge clk);
    eval_ack = 0;
    chk("R7 winner write", {19'd0, mem_we, mem_wdata} , {19'd0, 1'b1, cand[bi]});
    @(negedge clk);
    chk("R7 runner write", {19'd0, mem_we, mem_wdata}, {19'd0, 1'b1, cand[si]});
    @(negedge clk);
    chk("R8 done pulse", 32'(step_done), 32'd1);
    @(negedge clk);
    chk("R8 done single and go ignored", {30'd0, step_done, mem_re}, 32'd0);
    exp_mem[2*pair_m]     = cand[bi];
    exp_mem[2*pair_m + 1] = cand[si];
    bad_other = 0;
    for (int i = 0; i < NW; i++) if (mem[i] !== exp_mem[i]) bad_other++;
    chk("R7 R2 memory image", 32'(bad_other), 32'd0);
    pair_m = (pair_m + STRIDE) % NP;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R8 watchdog actual hung expected step completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] thr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset outputs", {28'd0, mem_re, mem_we, eval_req, step_done}, 32'd0);
    for (int md = 0; md < 2; md++) begin
      for (int t = 0; t < 4; t++) begin
        thr = (t == 0) ? 8'd0 : (t == 1) ? 8'd40 : (t == 2) ? 8'd128 : 8'd255;
        reload(md);
        for (int s = 0; s < 8; s++)
          run_step(thr, s % 3, (s % 4) == 1);
      end
    end
    summary();
    $finish;
  end
endmodule